// File: doc/BRIEF.md
# Maskable interrupt status controller

This block gathers the out-of-limit events of a temperature monitor into one 8-bit status register. It drives a single active-low interrupt pin through an 8-bit mask. Two temperature channels are checked on every conversion-done strobe: an internal reading and an external reading, each against its own high and low limit. A limit violation only counts once it has held for three conversions in a row. The over-temperature indications of both channels and a diode-fault flag are sampled on the same strobe. Two software flags and a general-purpose input pin complete the eight sources.

Software reaches the block through a small register port: configuration at address 0, status at address 1 and mask at address 2. Reads are combinational from `reg_addr`. Writes take effect at the clock edge on which `reg_wr_en` is high. A write of 1 clears a latched event. After such a clear, that temperature source is disarmed. It stays quiet while the reading remains out of limit, and it is re-armed after three consecutive in-limit conversions. A soft reset through configuration bit 4 restores all registers and re-arms every source at once.

The conversion inputs form a plain strobe, not a valid/ready stream. The block accepts every strobe in the cycle it arrives and never applies back-pressure, so the converter needs no ready signal. All inputs are assumed to be synchronous to `clk`.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, configuration reads 0x21, status reads 0x00, mask reads 0x00 and `irq_n` is high.
- R2: A violation on a channel sets its status bit only on the third consecutive conversion that violates. The internal channel sets bit 0 and the external channel sets bit 5. The bit is set at the clock edge of that third strobe.
- R3: An in-limit conversion between violations restarts the count of three.
- R4: Writing 1 to status bits 0, 3, 5, 6 or 7 clears that bit. Writing 0 to these bits leaves them unchanged.
- R5: Once a set temperature bit is cleared, further violations do not set it again. Three consecutive in-limit conversions re-arm the source, and three more consecutive violations are then needed to set the bit.
- R6: Status bits 1 and 2 are software flags that take the value written to them.
- R7: Status bit 4 always equals `gpi` XOR configuration bit 6, where bit 6 is the invert control. Writes to status bit 4 have no effect.
- R8: On a conversion strobe, `int_therm` sets bit 3, `ext_therm` sets bit 6 and `diode_fault` sets bit 7. Without a strobe, these inputs change nothing.
- R9: A mask bit at 1 removes the matching status bit from the interrupt. The status bit itself still sets.
- R10: `irq_n` is low exactly when configuration bit 1 (interrupt enable) is 1 and at least one unmasked status bit is 1.
- R11: Writing configuration with bit 4 set restores configuration to 0x21, status to 0x00 and mask to 0x00. It re-arms both temperature sources immediately. Configuration bit 4 always reads 0.
- R12: Readings and limits are compared as signed two's complement values. A reading counts as a violation only when it is strictly above the high limit or strictly below the low limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle conversion-done strobe |
| int_temp | input | 8 | Internal reading, signed |
| int_hi | input | 8 | Internal high limit, signed |
| int_lo | input | 8 | Internal low limit, signed |
| ext_temp | input | 8 | External reading, signed |
| ext_hi | input | 8 | External high limit, signed |
| ext_lo | input | 8 | External low limit, signed |
| int_therm | input | 1 | Internal over-temperature indication |
| ext_therm | input | 1 | External over-temperature indication |
| diode_fault | input | 1 | External diode fault indication |
| gpi | input | 1 | General-purpose input pin |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 configuration, 1 status, 2 mask |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A strobe or a register write that is applied before a rising edge shows up in the status, mask and configuration read-back right after that edge. It also reaches `irq_n` in the same edge, because `irq_n` is combinational from the registers. The `gpi` pin and the invert bit reach status bit 4 and `irq_n` with no edge at all. The bench changes inputs on the falling edge and holds them across one rising edge. It then reads the registers and samples `irq_n` one time unit after the next falling edge, so each check looks at the state one edge after its stimulus. The qualification tests count strobes one at a time and check both sides of the third strobe, the strobe before it and the strobe on which the bit sets.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW = 8;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;

  localparam int B_INT_ERR  = 0;
  localparam int B_FLAG_A   = 1;
  localparam int B_FLAG_B   = 2;
  localparam int B_INT_OT   = 3;
  localparam int B_PIN      = 4;
  localparam int B_EXT_ERR  = 5;
  localparam int B_EXT_OT   = 6;
  localparam int B_DIODE    = 7;

  localparam int C_IEN  = 1;
  localparam int C_SRST = 4;
  localparam int C_PINV = 6;

  localparam logic [DW-1:0] CFG_DEFAULT = 8'h21;
  localparam logic [DW-1:0] W1C_BITS    = 8'hE9;
  localparam logic [DW-1:0] FLAG_BITS   = 8'h06;
  localparam logic [DW-1:0] PIN_BIT     = 8'h10;
endpackage

// File: rtl/irq_limit_cmp.sv
module irq_limit_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic         viol_o
);
  logic above, below;
  always_comb begin
    above  = $signed(val_i) > $signed(hi_i);
    below  = $signed(val_i) < $signed(lo_i);
    viol_o = above | below;
  end
endmodule

// File: rtl/irq_event_qual.sv
module irq_event_qual #(
  parameter int QUAL_CNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm_i,
  input  logic disarm_i,
  input  logic conv_i,
  input  logic viol_i,
  output logic set_o
);
  localparam int QC = (QUAL_CNT < 2) ? 2 : QUAL_CNT;
  localparam int CW = $clog2(QC);
  localparam logic [CW-1:0] LAST = CW'(QC - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  always_comb set_o = conv_i && armed_q && viol_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (rearm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (conv_i) begin
      if (armed_q) begin
        if (!viol_i)            cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end else begin
        if (viol_i)             cnt_q <= '0;
        else if (cnt_q == LAST) begin
          armed_q <= 1'b1;
          cnt_q   <= '0;
        end else                cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm_i && !rearm_i) |=> !armed_q);
  p_rearm_now_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> (armed_q && cnt_q == '0));
  p_arm_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> ($past(rearm_i) || ($past(conv_i) && !$past(viol_i))));
  p_run_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_i && !viol_i && armed_q && !rearm_i && !disarm_i) |=> (cnt_q == '0));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          conv_i,
  input  logic [1:0]    qual_set_i,
  input  logic          int_ot_i,
  input  logic          ext_ot_i,
  input  logic          diode_i,
  input  logic          pin_i,
  output logic [1:0]    disarm_o,
  output logic          soft_rst_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_n_o
);
  logic [DW-1:0] cfg_q, stat_q, mask_q;
  logic [DW-1:0] stat_eff, clr_vec, set_vec, stat_nxt;
  logic          wr_cfg, wr_stat, wr_mask;

  always_comb begin
    wr_cfg     = wr_en_i && (addr_i == A_CFG);
    wr_stat    = wr_en_i && (addr_i == A_STAT);
    wr_mask    = wr_en_i && (addr_i == A_MASK);
    soft_rst_o = wr_cfg && wdata_i[C_SRST];

    clr_vec = wr_stat ? (wdata_i & W1C_BITS) : '0;
    set_vec = '0;
    set_vec[B_INT_ERR] = qual_set_i[0];
    set_vec[B_EXT_ERR] = qual_set_i[1];
    set_vec[B_INT_OT]  = conv_i && int_ot_i;
    set_vec[B_EXT_OT]  = conv_i && ext_ot_i;
    set_vec[B_DIODE]   = conv_i && diode_i;

    stat_nxt = (stat_q & ~clr_vec) | set_vec;
    if (wr_stat) stat_nxt = (stat_nxt & ~FLAG_BITS) | (wdata_i & FLAG_BITS);
    stat_nxt = stat_nxt & ~PIN_BIT;

    disarm_o[0] = clr_vec[B_INT_ERR] && stat_q[B_INT_ERR];
    disarm_o[1] = clr_vec[B_EXT_ERR] && stat_q[B_EXT_ERR];

    stat_eff        = stat_q;
    stat_eff[B_PIN] = pin_i ^ cfg_q[C_PINV];

    irq_n_o = !(cfg_q[C_IEN] && (|(stat_eff & ~mask_q)));

    case (addr_i)
      A_CFG:   rdata_o = cfg_q;
      A_STAT:  rdata_o = stat_eff;
      A_MASK:  rdata_o = mask_q;
      default: rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_DEFAULT;
      stat_q <= '0;
      mask_q <= '0;
    end else if (soft_rst_o) begin
      cfg_q  <= CFG_DEFAULT;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= wdata_i & ~(DW'(1) << C_SRST);
      if (wr_mask) mask_q <= wdata_i;
      stat_q <= stat_nxt;
    end
  end

  p_srst_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (cfg_q == CFG_DEFAULT && stat_q == '0 && mask_q == '0));
  p_flag_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (stat_q[B_FLAG_B:B_FLAG_A] == $past(wdata_i[B_FLAG_B:B_FLAG_A])));
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata_i[B_INT_OT] && !conv_i) |=> !stat_q[B_INT_OT]);
  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wdata_i)));
  p_temp_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[B_INT_ERR]) |-> $past(qual_set_i[0]));
  p_ot_needs_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[B_EXT_OT]) |-> $past(conv_i));
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[C_IEN] |-> irq_n_o);

  always_comb begin
    if (rst_n) begin
      a_srst_bit_r11: assert (!cfg_q[C_SRST]);
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int QUAL_CNT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic [DW-1:0] int_temp,
  input  logic [DW-1:0] int_hi,
  input  logic [DW-1:0] int_lo,
  input  logic [DW-1:0] ext_temp,
  input  logic [DW-1:0] ext_hi,
  input  logic [DW-1:0] ext_lo,
  input  logic          int_therm,
  input  logic          ext_therm,
  input  logic          diode_fault,
  input  logic          gpi,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_n
);
  localparam int NCH = 2;

  logic [NCH-1:0][DW-1:0] rd_v, hi_v, lo_v;
  logic [NCH-1:0]         viol, qset, disarm;
  logic                   soft_rst;

  always_comb begin
    rd_v[0] = int_temp; hi_v[0] = int_hi; lo_v[0] = int_lo;
    rd_v[1] = ext_temp; hi_v[1] = ext_hi; lo_v[1] = ext_lo;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    irq_limit_cmp #(.W(DW)) u_cmp (
      .val_i (rd_v[g]),
      .hi_i  (hi_v[g]),
      .lo_i  (lo_v[g]),
      .viol_o(viol[g])
    );
    irq_event_qual #(.QUAL_CNT(QUAL_CNT)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .rearm_i (soft_rst),
      .disarm_i(disarm[g]),
      .conv_i  (conv_valid),
      .viol_i  (viol[g]),
      .set_o   (qset[g])
    );
  end

  irq_status_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (reg_wr_en),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .conv_i    (conv_valid),
    .qual_set_i(qset),
    .int_ot_i  (int_therm),
    .ext_ot_i  (ext_therm),
    .diode_i   (diode_fault),
    .pin_i     (gpi),
    .disarm_o  (disarm),
    .soft_rst_o(soft_rst),
    .rdata_o   (reg_rdata),
    .irq_n_o   (irq_n)
  );
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_valid = 1'b0;
  logic [7:0] int_temp = 8'd20, int_hi = 8'd50, int_lo = 8'd10;
  logic [7:0] ext_temp = 8'd20, ext_hi = 8'd40, ext_lo = 8'd0;
  logic       int_therm = 1'b0, ext_therm = 1'b0, diode_fault = 1'b0, gpi = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
    .int_temp(int_temp), .int_hi(int_hi), .int_lo(int_lo),
    .ext_temp(ext_temp), .ext_hi(ext_hi), .ext_lo(ext_lo),
    .int_therm(int_therm), .ext_therm(ext_therm), .diode_fault(diode_fault),
    .gpi(gpi), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    #1;
    chk(req, {7'd0, irq_n}, {7'd0, exp});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic conv(input logic [7:0] ti, input logic [7:0] te,
                      input logic ot_i, input logic ot_e, input logic df);
    int_temp = ti; ext_temp = te;
    int_therm = ot_i; ext_therm = ot_e; diode_fault = df;
    conv_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    conv_valid = 1'b0; int_therm = 1'b0; ext_therm = 1'b0; diode_fault = 1'b0;
  endtask

  task automatic t_reset;
    chk_reg("R1 cfg", 2'd0, 8'h21);
    chk_reg("R1 status", 2'd1, 8'h00);
    chk_reg("R1 mask", 2'd2, 8'h00);
    chk_irq("R1 irq_n", 1'b1);
  endtask

  task automatic t_qualify;
    conv(8'd60, 8'd20, 0, 0, 0);
    conv(8'd60, 8'd20, 0, 0, 0);
    chk_reg("R2 two violations", 2'd1, 8'h00);
    conv(8'd60, 8'd20, 0, 0, 0);
    chk_reg("R2 third violation", 2'd1, 8'h01);
    chk_irq("R10 disabled", 1'b1);
    wr(2'd0, 8'h23);
    chk_reg("R10 cfg", 2'd0, 8'h23);
    chk_irq("R10 enabled", 1'b0);
  endtask

  task automatic t_restart;
    conv(8'd20, 8'd50, 0, 0, 0);
    conv(8'd20, 8'd50, 0, 0, 0);
    conv(8'd20, 8'd20, 0, 0, 0);
    conv(8'd20, 8'd50, 0, 0, 0);
    conv(8'd20, 8'd50, 0, 0, 0);
    chk_reg("R3 broken run", 2'd1, 8'h01);
    conv(8'd20, 8'd50, 0, 0, 0);
    chk_reg("R3 ext set", 2'd1, 8'h21);
  endtask

  task automatic t_clear_rearm;
    wr(2'd1, 8'h21);
    chk_reg("R4 cleared", 2'd1, 8'h00);
    chk_irq("R10 none", 1'b1);
    for (int i = 0; i < 4; i++) conv(8'd60, 8'd20, 0, 0, 0);
    chk_reg("R5 disarmed", 2'd1, 8'h00);
    conv(8'd20, 8'd20, 0, 0, 0);
    conv(8'd20, 8'd20, 0, 0, 0);
    conv(8'd60, 8'd20, 0, 0, 0);
    for (int i = 0; i < 3; i++) conv(8'd20, 8'd20, 0, 0, 0);
    conv(8'd60, 8'd20, 0, 0, 0);
    conv(8'd60, 8'd20, 0, 0, 0);
    chk_reg("R5 rearmed two", 2'd1, 8'h00);
    conv(8'd60, 8'd20, 0, 0, 0);
    chk_reg("R5 rearmed set", 2'd1, 8'h01);
    wr(2'd1, 8'h00);
    chk_reg("R4 write zero", 2'd1, 8'h01);
  endtask

  task automatic t_flags;
    wr(2'd1, 8'hFF);
    chk_reg("R6 flags set", 2'd1, 8'h06);
    chk_irq("R6 flag irq", 1'b0);
    wr(2'd1, 8'h02);
    chk_reg("R6 one flag", 2'd1, 8'h02);
    wr(2'd1, 8'h00);
    chk_reg("R6 flags clear", 2'd1, 8'h00);
    chk_irq("R6 no irq", 1'b1);
  endtask

  task automatic t_gpi;
    gpi = 1'b1;
    chk_reg("R7 pin high", 2'd1, 8'h10);
    chk_irq("R7 pin irq", 1'b0);
    wr(2'd1, 8'h10);
    chk_reg("R7 write ignored", 2'd1, 8'h10);
    wr(2'd0, 8'h63);
    chk_reg("R7 inverted", 2'd1, 8'h00);
    chk_irq("R7 inverted irq", 1'b1);
    gpi = 1'b0;
    chk_reg("R7 inverted low", 2'd1, 8'h10);
    wr(2'd0, 8'h23);
    chk_reg("R7 restore", 2'd1, 8'h00);
  endtask

  task automatic t_therm;
    int_therm = 1'b1; ext_therm = 1'b1; diode_fault = 1'b1;
    repeat (3) @(negedge clk);
    int_therm = 1'b0; ext_therm = 1'b0; diode_fault = 1'b0;
    chk_reg("R8 no strobe", 2'd1, 8'h00);
    conv(8'd20, 8'd20, 1, 1, 1);
    chk_reg("R8 all set", 2'd1, 8'hC8);
    chk_irq("R8 irq", 1'b0);
    wr(2'd1, 8'h40);
    chk_reg("R4 partial", 2'd1, 8'h88);
    wr(2'd1, 8'h88);
    chk_reg("R4 rest", 2'd1, 8'h00);
  endtask

  task automatic t_mask;
    wr(2'd2, 8'h08);
    chk_reg("R9 mask", 2'd2, 8'h08);
    conv(8'd20, 8'd20, 1, 0, 0);
    chk_reg("R9 status still set", 2'd1, 8'h08);
    chk_irq("R9 masked", 1'b1);
    wr(2'd2, 8'h00);
    chk_irq("R9 unmasked", 1'b0);
    wr(2'd1, 8'h08);
    chk_irq("R9 cleared", 1'b1);
  endtask

  task automatic t_softrst;
    wr(2'd2, 8'h55);
    wr(2'd1, 8'h06);
    wr(2'd0, 8'h10);
    chk_reg("R11 cfg", 2'd0, 8'h21);
    chk_reg("R11 status", 2'd1, 8'h00);
    chk_reg("R11 mask", 2'd2, 8'h00);
    chk_irq("R11 irq_n", 1'b1);
    for (int i = 0; i < 3; i++) conv(8'd60, 8'd20, 0, 0, 0);
    chk_reg("R11 rearmed", 2'd1, 8'h01);
  endtask

  task automatic t_signed;
    wr(2'd0, 8'h10);
    int_hi = 8'h10; int_lo = 8'hF6;
    for (int i = 0; i < 3; i++) conv(8'hFF, 8'd20, 0, 0, 0);
    chk_reg("R12 minus one", 2'd1, 8'h00);
    for (int i = 0; i < 3; i++) conv(8'h10, 8'd20, 0, 0, 0);
    chk_reg("R12 equal high", 2'd1, 8'h00);
    for (int i = 0; i < 3; i++) conv(8'hF6, 8'd20, 0, 0, 0);
    chk_reg("R12 equal low", 2'd1, 8'h00);
    for (int i = 0; i < 3; i++) conv(8'hF5, 8'd20, 0, 0, 0);
    chk_reg("R12 below low", 2'd1, 8'h01);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_qualify();
    t_restart();
    t_clear_rearm();
    t_flags();
    t_gpi();
    t_therm();
    t_mask();
    t_softrst();
    t_signed();
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
  end
endmodule